// File: doc/BRIEF.md
# Eight-Output I2C Port Expander

This block is an I2C slave that owns one 8-bit output register, and that register drives eight push-pull output pins. Each address-select input is a 2-bit code that tells the block how one pin is wired: 0 means tied to ground, 1 means tied to supply, 2 means tied to the data line and 3 means tied to the clock line. The two codes together fill the low four bits of the 7-bit slave address. They also set the value the register takes at power-up, four output bits per code.

A master writes the outputs by sending the slave address with the write flag and then one or more data bytes. Each byte reaches the pins once its acknowledge clock ends. A read does not return the register. It returns the logic levels actually present on the output pins, sampled at the start of each byte.

A separate abort input clears the bus interface back to idle at once. The abort does not touch the output register. A standby output is high whenever no transfer is in progress.

Top module: `port_out8_i2c`

## Requirements
- R1: The slave address is binary 101 followed by (hiCode XOR 2'b10) and then loCode. The 8th bit after START is the direction bit, where 1 means read. On an address match the block pulls the data line low for the acknowledge clock.
- R2: On an address mismatch the block never pulls the data line low. It ignores the rest of the transfer and leaves the output register unchanged. It responds again only after a new START, which may be a repeated START.
- R3: While rstN is low, output bits 3..0 load all zeros if loCode is 0 (ground) and all ones for any other code.
- R4: While rstN is low, output bits 7..4 load all zeros if hiCode is 0 (ground) and all ones for any other code.
- R5: A written data byte reaches outReg on the falling clock edge that ends its acknowledge bit. outReg keeps its old value while the eight data bits are still being clocked in.
- R6: Further data bytes in the same write transfer each overwrite outReg in turn.
- R7: A read returns pinLevel, sampled at the start of each byte, with the most significant bit first. A byte that the master acknowledges is followed by a freshly sampled byte. A master not-acknowledge ends the read.
- R8: Asserting busAbort returns the bus interface to idle at once. Standby goes high, the rest of that transfer gets no acknowledge, and outReg is unchanged.
- R9: standby is high from reset, after a STOP and after an abort. It is low from a START until the next STOP.
- R10: START is the data line falling while the clock line is high. STOP is the data line rising while the clock line is high. Both lines pass through a SYNC_LEN-stage synchronizer before the block uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset; loads outReg from the pin codes |
| busAbort | input | 1 | Active-high abort; clears the bus interface only |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| sdaDriveLow | output | 1 | Pull the data line low (open drain) |
| loCode | input | 2 | Wiring code of the low address pin |
| hiCode | input | 2 | Wiring code of the high address pin |
| pinLevel | input | 8 | Sampled logic levels at the output pins |
| outReg | output | 8 | Output register driving the pins |
| standby | output | 1 | High while the bus interface is idle |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and the 101 address prefix. With those defaults every code pair in the vector table maps to an address and a power-up pattern that can be worked out by hand. That covers a ground code on either nibble, a clock-line code and a data-line code. It also keeps the synchronizer delay small enough that a quarter clock phase of eight system cycles gives the bus edges time to settle. In addition, the bench feeds pin levels that differ from the register, so a read of pinLevel can be told apart from a read of outReg.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRITE,
    ST_WACK,
    ST_READ,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadPins;
    logic commit;
  } dpStrobe_t;

  localparam logic [1:0] PIN_GND = 2'd0;
  localparam logic [1:0] HI_SWAP = 2'b10;

endpackage

// File: rtl/pexp_datapath.sv
module pexp_datapath
  import pexp_pkg::*;
#(
  parameter int         SYNC_LEN    = 2,
  parameter logic [2:0] ADDR_PREFIX = 3'b101
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busRstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [1:0] loCode,
  input  logic [1:0] hiCode,
  input  logic [7:0] pinLevel,
  input  dpStrobe_t strobe,
  output logic [7:0] outReg,
  output logic      sclRise,
  output logic      sclFall,
  output logic      startSeen,
  output logic      stopSeen,
  output logic      sdaNow,
  output logic      byteFull,
  output logic      lastBit,
  output logic      addrMatch,
  output logic      rwBit,
  output logic      txBit
);

  localparam int BYTE_W = 8;
  localparam int NIB    = BYTE_W / 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [SYNC_LEN-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [6:0]        slaveAddr;
  logic [BYTE_W-1:0] powerVal;
  logic              commitNow;

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_LEN-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_LEN-1];
      sdaPrev <= sdaSync[SYNC_LEN-1];
    end
  end

  assign sclNow    = sclSync[SYNC_LEN-1];
  assign sdaNow    = sdaSync[SYNC_LEN-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobe.loadPins)      shiftReg <= pinLevel;
      else if (strobe.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      else if (strobe.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      if (strobe.clrCnt)                           bitCnt <= '0;
      else if (strobe.shiftIn || strobe.shiftOut)  bitCnt <= bitCnt + 1'b1;
    end
  end

  assign byteFull  = (bitCnt == CNT_W'(BYTE_W));
  assign lastBit   = (bitCnt == CNT_W'(BYTE_W - 1));
  assign slaveAddr = {ADDR_PREFIX, hiCode ^ HI_SWAP, loCode};
  assign addrMatch = (shiftReg[BYTE_W-1:1] == slaveAddr);
  assign rwBit     = shiftReg[0];
  assign txBit     = shiftReg[BYTE_W-1];

  // power-up value, one nibble per code
  assign powerVal = {{NIB{hiCode != PIN_GND}}, {NIB{loCode != PIN_GND}}};
  assign commitNow = strobe.commit;

  always_ff @(posedge clk) begin
    if (!rstN)          outReg <= powerVal;
    else if (commitNow) outReg <= shiftReg;
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!busRstN)
    bitCnt <= CNT_W'(BYTE_W));

  // register moves only on a commit strobe (R8, R5)
  assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(commitNow)) |-> $stable(outReg));

endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl
  import pexp_pkg::*;
(
  input  logic      clk,
  input  logic      busRstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      sdaNow,
  input  logic      byteFull,
  input  logic      lastBit,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaDriveLow,
  output logic      standby
);

  busState_t state, nextState;

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) state <= ST_IDLE;
    else          state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (stopSeen) begin
      nextState = ST_IDLE;
    end else if (startSeen) begin
      nextState     = ST_ADDR;
      strobe.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WRITE: begin
          if (sclRise && !byteFull) strobe.shiftIn = 1'b1;
          else if (sclFall && byteFull) begin
            if (state == ST_WRITE) nextState = ST_WACK;
            else                   nextState = addrMatch ? ST_AACK : ST_IGNORE;
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            strobe.clrCnt = 1'b1;
            if (rwBit) begin
              strobe.loadPins = 1'b1;
              nextState       = ST_READ;
            end else begin
              nextState = ST_WRITE;
            end
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            strobe.commit = 1'b1;
            strobe.clrCnt = 1'b1;
            nextState     = ST_WRITE;
          end
        end
        ST_READ: begin
          if (sclFall) begin
            if (lastBit) nextState = ST_RACK;
            else         strobe.shiftOut = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise && sdaNow) nextState = ST_IGNORE;
          else if (sclFall) begin
            strobe.loadPins = 1'b1;
            strobe.clrCnt   = 1'b1;
            nextState       = ST_READ;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_AACK) || (state == ST_WACK) ||
                       (state == ST_READ && !txBit);
  assign standby     = (state == ST_IDLE);

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!busRstN)
    stopSeen |=> standby);

  assert_nomatch_quiet_R2: assert property (@(posedge clk) disable iff (!busRstN)
    (state == ST_ADDR && sclFall && byteFull && !addrMatch && !startSeen) |=>
      (!sdaDriveLow && !standby));

  assert_commit_on_fall_R5: assert property (@(posedge clk) disable iff (!busRstN)
    strobe.commit |-> sclFall);

  assert_ack_matched_R1: assert property (@(posedge clk) disable iff (!busRstN)
    (state == ST_AACK) |-> addrMatch);

endmodule

// File: rtl/port_out8_i2c.sv
module port_out8_i2c
  import pexp_pkg::*;
#(
  parameter int         SYNC_LEN    = 2,
  parameter logic [2:0] ADDR_PREFIX = 3'b101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAbort,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic [1:0] loCode,
  input  logic [1:0] hiCode,
  input  logic [7:0] pinLevel,
  output logic [7:0] outReg,
  output logic       standby
);

  logic busRstN;
  dpStrobe_t strobe;
  logic sclRise, sclFall, startSeen, stopSeen, sdaNow;
  logic byteFull, lastBit, addrMatch, rwBit, txBit;

  assign busRstN = rstN & ~busAbort;

  pexp_datapath #(.SYNC_LEN(SYNC_LEN), .ADDR_PREFIX(ADDR_PREFIX)) dp (
    .clk(clk), .rstN(rstN), .busRstN(busRstN),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .loCode(loCode), .hiCode(hiCode), .pinLevel(pinLevel),
    .strobe(strobe), .outReg(outReg),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaNow(sdaNow),
    .byteFull(byteFull), .lastBit(lastBit), .addrMatch(addrMatch),
    .rwBit(rwBit), .txBit(txBit)
  );

  pexp_ctrl ctrl (
    .clk(clk), .busRstN(busRstN),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaNow(sdaNow),
    .byteFull(byteFull), .lastBit(lastBit), .addrMatch(addrMatch),
    .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow), .standby(standby)
  );

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(busAbort) |-> (standby && !sdaDriveLow));

endmodule

// File: tb/port_out8_i2c_test.sv
module port_out8_i2c_test;

  localparam int Q = 8;
  localparam int H = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0, busAbort = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] loCode = 2'd0, hiCode = 2'd0;
  logic [7:0] pinFault = 8'h00;
  logic       sdaDriveLow, standby;
  logic [7:0] outReg, pinLevel;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  assign pinLevel = outReg ^ pinFault;

  int total = 0;
  int bad   = 0;

  port_out8_i2c uut (
    .clk(clk), .rstN(rstN), .busAbort(busAbort),
    .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .loCode(loCode), .hiCode(hiCode), .pinLevel(pinLevel),
    .outReg(outReg), .standby(standby)
  );

  // {hiCode, loCode, address, power-up value, data byte}
  localparam logic [26:0] VEC [6] = '{
    {2'd0, 2'd0, 7'h58, 8'h00, 8'hA5},
    {2'd1, 2'd1, 7'h5D, 8'hFF, 8'h3C},
    {2'd2, 2'd3, 7'h53, 8'hFF, 8'h81},
    {2'd0, 2'd2, 7'h5A, 8'h0F, 8'h7E},
    {2'd3, 2'd0, 7'h54, 8'hF0, 8'h12},
    {2'd1, 2'd0, 7'h5C, 8'hF0, 8'hC9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H / 2);
    b = sdaBus;  waitClk(H / 2);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(ack);
  endtask

  task automatic recvByte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d1, d2;
    logic [6:0] addr;

    // table walk: power-up value, addressing and single-byte write per code pair
    for (int v = 0; v < 6; v++) begin
      hiCode = VEC[v][26:25];
      loCode = VEC[v][24:23];
      addr   = VEC[v][22:16];
      rstN = 1'b0; waitClk(3);
      rstN = 1'b1; waitClk(2);
      check("R3 low nibble power-up", {28'd0, outReg[3:0]}, {28'd0, VEC[v][11:8]});
      check("R4 high nibble power-up", {28'd0, outReg[7:4]}, {28'd0, VEC[v][15:12]});
      check("R9 standby after reset", {31'd0, standby}, 32'd1);
      busStart();
      check("R10 START clears standby", {31'd0, standby}, 32'd0);
      sendByte({addr, 1'b0}, ack);
      check("R1 address ack", {31'd0, ack}, 32'd0);
      sendByte(VEC[v][7:0], ack);
      check("R5 data ack", {31'd0, ack}, 32'd0);
      check("R5 outReg after write", {24'd0, outReg}, {24'd0, VEC[v][7:0]});
      busStop(); waitClk(4);
      check("R9 standby after STOP", {31'd0, standby}, 32'd1);
      busStart();
      sendByte({addr ^ 7'h01, 1'b0}, ack);
      check("R2 no ack on mismatch", {31'd0, ack}, 32'd1);
      sendByte(~VEC[v][7:0], ack);
      check("R2 data ignored no ack", {31'd0, ack}, 32'd1);
      busStop(); waitClk(4);
      check("R2 outReg unchanged", {24'd0, outReg}, {24'd0, VEC[v][7:0]});
    end

    // last entry codes stay: address 0x5C, outReg 0xC9
    addr = 7'h5C;

    // R5 timing and R6 multi-byte overwrite
    busStart();
    sendByte({addr, 1'b0}, ack);
    for (int i = 7; i >= 0; i--) sendBit(8'h3C >> i);
    check("R5 outReg held before ack clock", {24'd0, outReg}, 32'hC9);
    recvBit(ack);
    check("R5 ack of data", {31'd0, ack}, 32'd0);
    check("R5 outReg after ack", {24'd0, outReg}, 32'h3C);
    sendByte(8'h66, ack);
    check("R6 second byte overwrites", {24'd0, outReg}, 32'h66);
    sendByte(8'h99, ack);
    check("R6 third byte overwrites", {24'd0, outReg}, 32'h99);
    busStop(); waitClk(4);

    // R7 read returns pin levels, resampled per byte
    pinFault = 8'h0F;
    busStart();
    sendByte({addr, 1'b1}, ack);
    check("R7 read address ack", {31'd0, ack}, 32'd0);
    recvByte(d1);
    pinFault = 8'hF0;
    sendBit(1'b0);
    recvByte(d2);
    sendBit(1'b1);
    busStop(); waitClk(4);
    check("R7 first read byte is pin levels", {24'd0, d1}, 32'h96);
    check("R7 second read byte resampled", {24'd0, d2}, 32'h69);
    check("R7 read leaves outReg", {24'd0, outReg}, 32'h99);
    check("R7 standby after nack and STOP", {31'd0, standby}, 32'd1);
    pinFault = 8'h00;

    // R8 abort mid-write
    busStart();
    sendByte({addr, 1'b0}, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    check("R8 busy before abort", {31'd0, standby}, 32'd0);
    busAbort = 1'b1; waitClk(2);
    check("R8 standby during abort", {31'd0, standby}, 32'd1);
    busAbort = 1'b0; waitClk(2);
    check("R8 standby after abort", {31'd0, standby}, 32'd1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    recvBit(ack);
    check("R8 no ack after abort", {31'd0, ack}, 32'd1);
    check("R8 outReg unchanged", {24'd0, outReg}, 32'h99);
    busStop(); waitClk(4);
    busStart();
    sendByte({addr, 1'b0}, ack);
    sendByte(8'h42, ack);
    busStop(); waitClk(4);
    check("R8 write after abort", {24'd0, outReg}, 32'h42);

    // R2 mismatch then repeated START to the right address
    busStart();
    sendByte({7'h2C, 1'b0}, ack);
    check("R2 foreign address nack", {31'd0, ack}, 32'd1);
    busStart();
    sendByte({addr, 1'b0}, ack);
    check("R2 repeated START re-arms", {31'd0, ack}, 32'd0);
    sendByte(8'h24, ack);
    busStop(); waitClk(4);
    check("R2 write after repeated START", {24'd0, outReg}, 32'h24);

    // R3/R4 reset reload does not depend on bus state; abort alone keeps value
    busAbort = 1'b1; waitClk(3); busAbort = 1'b0; waitClk(3);
    check("R8 abort keeps register", {24'd0, outReg}, 32'h24);
    hiCode = 2'd2; loCode = 2'd0;
    rstN = 1'b0; waitClk(3); rstN = 1'b1; waitClk(2);
    check("R3 R4 reload from codes", {24'd0, outReg}, 32'hF0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule